// File: doc/BRIEF.md
# PLL Phase Edge Lock Detector

This block decides whether a phase-locked loop is in lock. It does this by watching two one-cycle edge pulses on a fast system clock. One pulse comes from the divided reference and the other from the divided oscillator. Each comparison opens a window on whichever edge comes first and waits for the edge from the other side.

A comparison is good when the partner edge arrives within the window. Each good comparison raises a saturating count. Once the count reaches a programmable threshold, the lock flag rises. A single bad comparison clears the count and drops lock in the same clock edge. The flag is driven to a pin output and to a status bit.

A single configuration word carries four fields: the enable, the window mode, the threshold and a five-bit window code. In fixed mode the window is a parameter width given in system-clock cycles. In programmable mode the window is decoded from the five-bit code.

Top module: `edge_lock_monitor`

## Requirements
- R1: While `cfg[0]` (enable) is 0, the lock outputs read 0 and the good-pair count is held at zero from the next clock edge on. Edges seen while disabled are not counted.
- R2: A window opens on the first edge of either kind. A partner edge that arrives d cycles later, with 0 <= d <= W, makes a good pair. Both arrival orders count, and coincident edges (d = 0) count.
- R3: Lock rises at the clock edge that samples the completing edge of a good pair that brings the count to at least the threshold `cfg[4:2]`. A threshold of 0 behaves as 1.
- R4: If no partner edge has arrived W cycles after the window opened, the comparison fails. The count clears and lock falls at that edge.
- R5: A second edge of the same kind that arrives before the partner is a failed comparison. That second edge then opens a new window.
- R6: After a failure, lock rises again only once the count has climbed back to the threshold.
- R7: `cfg[1]` (mode) = 0 selects a fixed window of FIXED_WIN cycles, and in this mode the window code is ignored. `cfg[1]` = 1 selects the programmable window.
- R8: In programmable mode the window is W = (b + 1) << s cycles, where b = `cfg[7:5]` and s = `cfg[9:8]`. This gives W from 1 to 64.
- R9: `lock_stat` always equals `lock_pin`. A value of 1 means locked.
- R10: The good-pair count saturates at 2^CNT_W - 1 and does not wrap. A lock held by a saturated count therefore stays up.
- R11: The synchronous, active-high `rst` clears the count, the lock flag and any open window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_pulse | input | 1 | One-cycle divided-reference edge |
| osc_pulse | input | 1 | One-cycle divided-oscillator edge |
| cfg | input | 10 | {shift[1:0], base[2:0], threshold[2:0], mode, enable} |
| lock_pin | output | 1 | Lock flag for the output pin |
| lock_stat | output | 1 | Lock flag as a status bit |

## Verification
The bench builds the block with FIXED_WIN = 3 and CNT_W = 3. With CNT_W = 3 the count ceiling equals the largest threshold, 7, so a counter that wraps instead of saturating drops lock within a few extra pairs. The bench sweeps all 32 window codes in both arrival orders and probes each window exactly at W and at W + 1 cycles. It also sweeps every threshold value and checks the lock flag after each individual pair.

// File: rtl/lock_det_pkg.sv
package lock_det_pkg;

    localparam int CFG_W = 10;
    localparam int THR_W = 3;

    typedef struct packed {
        logic [1:0]       shift;
        logic [2:0]       base;
        logic [THR_W-1:0] thr;
        logic             mode;
        logic             en;
    } lock_cfg_t;

endpackage

// File: rtl/win_decode.sv
module win_decode #(
    parameter int WIN_W     = 7,
    parameter int FIXED_WIN = 3
) (
    input  logic             mode,
    input  logic [2:0]       base,
    input  logic [1:0]       shift,
    output logic [WIN_W-1:0] win
);
    localparam logic [WIN_W-1:0] FIXED_V = WIN_W'(FIXED_WIN);

    logic [WIN_W-1:0] prog_v;

    always_comb begin
        prog_v = WIN_W'({1'b0, base} + 4'd1) << shift;
        win    = mode ? prog_v : FIXED_V;
    end
endmodule

// File: rtl/pair_window.sv
module pair_window #(
    parameter int WIN_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             ref_p,
    input  logic             osc_p,
    input  logic [WIN_W-1:0] win,
    output logic             pair_ok,
    output logic             pair_fail
);
    typedef struct packed {
        logic             open;
        logic             side_ref;
        logic [WIN_W-1:0] age;
    } win_st_t;

    win_st_t st_d, st_q;
    logic    partner, same;

    always_comb begin
        st_d      = st_q;
        pair_ok   = 1'b0;
        pair_fail = 1'b0;
        partner   = st_q.side_ref ? osc_p : ref_p;
        same      = st_q.side_ref ? ref_p : osc_p;
        if (!en) begin
            st_d = '0;
        end else if (!st_q.open) begin
            if (ref_p && osc_p) begin
                pair_ok = 1'b1;
            end else if (ref_p || osc_p) begin
                st_d.open     = 1'b1;
                st_d.side_ref = ref_p;
                st_d.age      = WIN_W'(1);
            end
        end else if (partner) begin
            pair_ok = 1'b1;
            if (same) st_d.age = WIN_W'(1);
            else      st_d     = '0;
        end else if (same) begin
            pair_fail = 1'b1;
            st_d.age  = WIN_W'(1);
        end else if (st_q.age >= win) begin
            pair_fail = 1'b1;
            st_d      = '0;
        end else begin
            st_d.age = st_q.age + WIN_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R2
    verdict_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pair_ok, pair_fail}));

    // R4
    idle_age_chk: assert property (@(posedge clk) disable iff (rst)
        !st_q.open |-> st_q.age == '0);
endmodule

// File: rtl/lock_counter.sv
module lock_counter #(
    parameter int CNT_W = 4,
    parameter int THR_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             pair_ok,
    input  logic             pair_fail,
    input  logic [THR_W-1:0] thr,
    output logic             lock
);
    localparam int              CMP_W   = (CNT_W > THR_W) ? CNT_W : THR_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             lock;
    } cnt_st_t;

    cnt_st_t          st_d, st_q;
    logic [CMP_W-1:0] eff_thr;

    always_comb begin
        st_d    = st_q;
        eff_thr = (thr == '0) ? CMP_W'(1) : CMP_W'(thr);
        if (!en || pair_fail)
            st_d.cnt = '0;
        else if (pair_ok && st_q.cnt != CNT_MAX)
            st_d.cnt = st_q.cnt + CNT_W'(1);
        st_d.lock = en && (CMP_W'(st_d.cnt) >= eff_thr);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign lock = st_q.lock;

    // R4
    fail_clears_chk: assert property (@(posedge clk) disable iff (rst)
        pair_fail |=> (st_q.cnt == '0 && !st_q.lock));

    // R1
    disabled_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (st_q.cnt == '0 && !st_q.lock));

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (en && pair_ok && !pair_fail && st_q.cnt == CNT_MAX) |=> st_q.cnt == CNT_MAX);

    // R3
    lock_needs_count_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.lock |-> st_q.cnt != '0);
endmodule

// File: rtl/edge_lock_monitor.sv
module edge_lock_monitor #(
    parameter int FIXED_WIN = 3,
    parameter int CNT_W     = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           ref_pulse,
    input  logic                           osc_pulse,
    input  logic [lock_det_pkg::CFG_W-1:0] cfg,
    output logic                           lock_pin,
    output logic                           lock_stat
);
    import lock_det_pkg::*;

    localparam int WIN_W = 7;

    lock_cfg_t        c;
    logic [WIN_W-1:0] win;
    logic             ok, fail, lock;

    assign c = lock_cfg_t'(cfg);

    win_decode #(.WIN_W(WIN_W), .FIXED_WIN(FIXED_WIN)) u_dec (
        .mode(c.mode), .base(c.base), .shift(c.shift), .win(win)
    );

    pair_window #(.WIN_W(WIN_W)) u_win (
        .clk(clk), .rst(rst), .en(c.en), .ref_p(ref_pulse), .osc_p(osc_pulse),
        .win(win), .pair_ok(ok), .pair_fail(fail)
    );

    lock_counter #(.CNT_W(CNT_W), .THR_W(THR_W)) u_cnt (
        .clk(clk), .rst(rst), .en(c.en), .pair_ok(ok), .pair_fail(fail),
        .thr(c.thr), .lock(lock)
    );

    assign lock_pin  = lock;
    assign lock_stat = lock;

    // R11
    reset_clears_chk: assert property (@(posedge clk) rst |=> !lock_pin);
endmodule

// File: tb/edge_lock_monitor_tb.sv
module edge_lock_monitor_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_pulse = 1'b0, osc_pulse = 1'b0;
    logic en = 1'b0, mode = 1'b0;
    logic [2:0] thr = 3'd1, base = 3'd0;
    logic [1:0] shf = 2'd0;
    logic [9:0] cfg;
    logic lock_pin, lock_stat;
    int n_chk = 0, n_err = 0;
    bit done = 1'b0;

    assign cfg = {shf, base, thr, mode, en};

    always #2 clk = ~clk;

    edge_lock_monitor #(.FIXED_WIN(3), .CNT_W(3)) u_dut (
        .clk(clk), .rst(rst), .ref_pulse(ref_pulse), .osc_pulse(osc_pulse),
        .cfg(cfg), .lock_pin(lock_pin), .lock_stat(lock_stat)
    );

    task automatic step(input logic r, input logic o);
        @(negedge clk);
        ref_pulse = r;
        osc_pulse = o;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic exp);
        n_chk++;
        if (lock_pin !== exp) begin
            n_err++;
            $display("FAIL %s: lock_pin=%b expected %b", tag, lock_pin, exp);
        end
        n_chk++;
        if (lock_stat !== lock_pin) begin
            n_err++;
            $display("FAIL R9 (%s): lock_stat=%b expected %b", tag, lock_stat, lock_pin);
        end
    endtask

    task automatic clear_all();
        en = 1'b0;
        step(0, 0);
        en = 1'b1;
    endtask

    task automatic send_pair(input logic first_ref, input int d);
        if (d == 0) begin
            step(1, 1);
        end else begin
            step(first_ref, !first_ref);
            for (int i = 1; i < d; i++) step(0, 0);
            step(!first_ref, first_ref);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        step(1, 1);
        step(0, 0);
        chk("R11 reset state", 1'b0);
        rst = 1'b0;
        step(0, 0);
        chk("R1 disabled after reset", 1'b0);

        // R8 and R2/R4: sweep every window code, both arrival orders
        mode = 1'b1;
        thr  = 3'd1;
        for (int code = 0; code < 32; code++) begin
            int w;
            base = code[2:0];
            shf  = code[4:3];
            w = ((code % 8) + 1) << (code / 8);
            for (int s = 0; s < 2; s++) begin
                clear_all();
                send_pair(s[0], w);
                chk($sformatf("R8 R2 code %0d delay W=%0d side %0d", code, w, s), 1'b1);
                clear_all();
                send_pair(s[0], w + 1);
                chk($sformatf("R8 R4 code %0d delay W+1 side %0d", code, s), 1'b0);
            end
        end

        // R7: fixed window of 3, code left at its maximum
        mode = 1'b0;
        base = 3'd7;
        shf  = 2'd3;
        clear_all(); send_pair(1'b0, 3); chk("R7 fixed delay 3", 1'b1);
        clear_all(); send_pair(1'b1, 4); chk("R7 fixed delay 4", 1'b0);
        clear_all(); send_pair(1'b1, 0); chk("R2 coincident edges", 1'b1);

        // R3: threshold sweep
        for (int t = 0; t < 8; t++) begin
            int eff;
            eff = (t == 0) ? 1 : t;
            thr = t[2:0];
            clear_all();
            for (int k = 1; k <= eff + 1; k++) begin
                send_pair(k[0], k % 3);
                chk($sformatf("R3 thr %0d after %0d pairs", t, k), k >= eff);
            end
        end

        // R5 / R6: same-kind repeat, then relock
        thr = 3'd3;
        clear_all();
        for (int k = 0; k < 3; k++) send_pair(1'b1, 1);
        chk("R3 locked before repeat", 1'b1);
        step(1, 0);
        chk("R5 first ref open", 1'b1);
        step(1, 0);
        chk("R5 repeated ref drops lock", 1'b0);
        step(0, 1);
        chk("R6 one pair after loss", 1'b0);
        send_pair(1'b0, 2);
        chk("R6 two pairs after loss", 1'b0);
        send_pair(1'b1, 1);
        chk("R6 relock at threshold", 1'b1);

        // R4: timeout with fixed window 3
        step(1, 0);
        step(0, 0);
        step(0, 0);
        chk("R4 still locked at age 2", 1'b1);
        step(0, 0);
        chk("R4 timeout drops lock", 1'b0);

        // R10: saturation with threshold 7 and 3-bit count
        thr = 3'd7;
        clear_all();
        for (int k = 1; k <= 12; k++) begin
            send_pair(k[0], 1);
            chk($sformatf("R10 pair %0d", k), k >= 7);
        end

        // R1: disable while locked
        en = 1'b0;
        step(1, 1);
        chk("R1 disable drops lock", 1'b0);
        for (int k = 0; k < 4; k++) send_pair(1'b1, 1);
        chk("R1 pairs ignored while disabled", 1'b0);
        thr = 3'd2;
        en  = 1'b1;
        send_pair(1'b0, 1);
        chk("R1 count held at zero", 1'b0);
        send_pair(1'b0, 1);
        chk("R1 lock after re-enable", 1'b1);

        // R11: reset while locked
        rst = 1'b1;
        step(0, 0);
        chk("R11 reset while locked", 1'b0);
        rst = 1'b0;
        send_pair(1'b1, 1);
        chk("R11 count cleared by reset", 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule